// File: doc/BRIEF.md
# Clock Output Gating and Strap Control

This block sits between the frequency-select sources of a clock generator and the enables of its clock outputs. Shortly after reset it captures a five-bit frequency-select code from strap pins. Three of those pins are shared with clock outputs and turn into outputs once the capture is done. A register bit then chooses whether the active select code comes from the captured straps or from a register field.

The block also gates two clock groups. The CPU group stops on a CPU stop request. The PCI group stops on a PCI stop request, unless the watchdog enable masks that request. A free-running PCI output never stops. An asynchronous power-down forces every run enable low. A tristate register bit releases every output. A voltage-ID override drives a register value onto five pins while its enable pin is high.

The strap capture is a three-state machine. WAIT counts reference cycles after reset; its transition CNT_DONE leads to LATCH. LATCH captures the pins; its transition CAPTURED leads to RUN, which is final. Each stop group has a two-state machine clocked on the falling edge of its group clock. RUN goes to HALT on STOP_SEEN. HALT goes back to RUN on START_SEEN.

Top module: `clk_gate_strap_ctrl`

## Requirements
- R1: After reset is released, the strap machine passes from WAIT through LATCH to RUN. `strap_done` rises SAMPLE_DELAY+1 reference edges after the release and then stays high.
- R2: `strap_oe` (3 bits; bit 0 drives strap bit 2, bit 2 drives strap bit 4) is 3'b000 while `strap_done` is low. After `strap_done` goes high it is 3'b111, unless tristate is set.
- R3: Once captured, the strap code is fixed. Later changes on `strap_in` do not change `sel_code` in strap mode.
- R4: With `reg_sel_src`=1, `sel_code` equals `reg_sel_code`. With 0, it equals the captured straps, which read as 5'b00000 before capture.
- R5: With `cpu_stop_n` low, `cpu_run` goes to 0 after synchronisation, while `pci_run` and `pcif_run` stay 1. Releasing the request restores `cpu_run`=1. Both run enables are 1 out of reset.
- R6: With `pci_stop_n` low, `pci_run` goes to 0 while `pcif_run` stays 1.
- R7: With `wdog_en`=1, a low `pci_stop_n` has no effect and `pci_run` stays 1.
- R8: `cpu_run` and `pci_run` change only while their own group clock is low.
- R9: With `pd_n` low, `cpu_run`, `pci_run` and `pcif_run` are 0 at once, without waiting for any clock edge.
- R10: With `reg_tristate`=1, `out_oe` is 0 and `strap_oe` is 3'b000. With 0, `out_oe` is 1.
- R11: With `vid_en` low, `vid_oe` is 0 and `vid_out` is 5'b00000. With it high, `vid_oe` is 1 and `vid_out` equals `reg_vid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock for strap timing |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down |
| cpu_clk | input | 1 | CPU group clock |
| pci_clk | input | 1 | PCI group clock |
| strap_in | input | 5 | Frequency-select strap pin values |
| reg_sel_src | input | 1 | 1 = select code from register, 0 = from straps |
| reg_sel_code | input | 5 | Register select code |
| reg_tristate | input | 1 | 1 = release all outputs |
| wdog_en | input | 1 | Watchdog enable; masks the PCI stop |
| cpu_stop_n | input | 1 | Active-low CPU group stop |
| pci_stop_n | input | 1 | Active-low PCI group stop |
| vid_en | input | 1 | Voltage-ID override enable pin |
| reg_vid | input | 5 | Voltage-ID override value |
| sel_code | output | 5 | Effective frequency-select code |
| strap_done | output | 1 | Strap capture complete |
| strap_oe | output | 3 | Output enables of the shared strap pins |
| cpu_run | output | 1 | CPU group run enable |
| pci_run | output | 1 | Stoppable PCI group run enable |
| pcif_run | output | 1 | Free-running PCI run enable |
| out_oe | output | 1 | Global output enable |
| vid_oe | output | 1 | Voltage-ID pin drive enable |
| vid_out | output | 5 | Voltage-ID drive value |

## Verification
Power-down and the watchdog-masked PCI stop can act on `pci_run` in the same cycle. The bench holds `pci_stop_n` low with `wdog_en` high and then drops `pd_n`. It expects `pci_run` at 0 at once, because power-down wins over the mask. After `pd_n` is released, it expects `pci_run` back at 1 once the group clock has toggled, because the mask still cancels the stop. A monitor checks that the group run enables never change while their group clock is high.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_LATCH = 2'd1,
        ST_RUN   = 2'd2
    } strap_st_e;

    typedef enum logic {
        G_RUN  = 1'b0,
        G_HALT = 1'b1
    } gate_st_e;
endpackage

// File: rtl/strap_fsm.sv
module strap_fsm
    import clkctl_pkg::*;
#(
    parameter int SAMPLE_DELAY = 16,
    parameter int CODE_W       = 5
) (
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] pins,
    output logic [CODE_W-1:0] strap_q,
    output logic              done
);
    localparam int CNT_W = $clog2(SAMPLE_DELAY + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_DELAY - 1);

    strap_st_e       state, next_state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_WAIT;
            cnt     <= '0;
            strap_q <= '0;
        end else begin
            state <= next_state;
            if (state == ST_WAIT)
                cnt <= cnt + 1'b1;
            if (state == ST_LATCH)
                strap_q <= pins;
        end
    end

    always_comb begin
        next_state = state;
        unique case (state)
            ST_WAIT:  if (cnt == CNT_LAST) next_state = ST_LATCH;
            ST_LATCH: next_state = ST_RUN;
            ST_RUN:   next_state = ST_RUN;
            default:  next_state = ST_WAIT;
        endcase
    end

    always_comb begin
        done = (state == ST_RUN);
    end

    // R1: the final state is kept
    a_r1_run_sticky: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state == ST_RUN) |=> (state == ST_RUN));

    // R3: captured code never moves once running
    a_r3_code_frozen: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ((state == ST_RUN) && $past(state == ST_RUN)) |-> $stable(strap_q));
endmodule

// File: rtl/stop_gate.sv
module stop_gate
    import clkctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic gclk,
    input  logic rst_n,
    input  logic run_req,
    output logic run_en
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   req_s;
    gate_st_e               state, next_state;

    always_ff @(posedge gclk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], run_req};
    end

    assign req_s = sync_q[SYNC_STAGES-1];

    // state changes on the falling edge, so the enable moves only while gclk is low
    always_ff @(negedge gclk or negedge rst_n) begin
        if (!rst_n) state <= G_RUN;
        else        state <= next_state;
    end

    always_comb begin
        next_state = state;
        unique case (state)
            G_RUN:   if (!req_s) next_state = G_HALT;
            G_HALT:  if (req_s)  next_state = G_RUN;
            default: next_state = G_RUN;
        endcase
    end

    always_comb begin
        run_en = (state == G_RUN);
    end

    // R5, R6: a synchronised stop request halts the group at the next falling edge
    a_r5_stop_follows: assert property (@(negedge gclk) disable iff (!rst_n)
        !req_s |=> (state == G_HALT));

    // R5: a synchronised run request restarts the group
    a_r5_start_follows: assert property (@(negedge gclk) disable iff (!rst_n)
        req_s |=> (state == G_RUN));
endmodule

// File: rtl/clk_gate_strap_ctrl.sv
module clk_gate_strap_ctrl
    import clkctl_pkg::*;
#(
    parameter int SAMPLE_DELAY = 16,
    parameter int SYNC_STAGES  = 2,
    parameter int CODE_W       = 5,
    parameter int VID_W        = 5,
    parameter int SHARED_PINS  = 3
) (
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic              pd_n,
    input  logic              cpu_clk,
    input  logic              pci_clk,
    input  logic [CODE_W-1:0] strap_in,
    input  logic              reg_sel_src,
    input  logic [CODE_W-1:0] reg_sel_code,
    input  logic              reg_tristate,
    input  logic              wdog_en,
    input  logic              cpu_stop_n,
    input  logic              pci_stop_n,
    input  logic              vid_en,
    input  logic [VID_W-1:0]  reg_vid,
    output logic [CODE_W-1:0] sel_code,
    output logic              strap_done,
    output logic [SHARED_PINS-1:0] strap_oe,
    output logic              cpu_run,
    output logic              pci_run,
    output logic              pcif_run,
    output logic              out_oe,
    output logic              vid_oe,
    output logic [VID_W-1:0]  vid_out
);
    localparam int NGRP = 2;

    logic [CODE_W-1:0] strap_q;
    logic [NGRP-1:0]   grp_clk, grp_req, grp_en;

    strap_fsm #(.SAMPLE_DELAY(SAMPLE_DELAY), .CODE_W(CODE_W)) u_strap (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .pins    (strap_in),
        .strap_q (strap_q),
        .done    (strap_done)
    );

    // group 0: CPU, group 1: stoppable PCI (watchdog masks its stop)
    assign grp_clk = {pci_clk, cpu_clk};
    assign grp_req = {pci_stop_n | wdog_en, cpu_stop_n};

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        stop_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
            .gclk    (grp_clk[g]),
            .rst_n   (rst_n),
            .run_req (grp_req[g]),
            .run_en  (grp_en[g])
        );
    end

    always_comb begin
        sel_code = reg_sel_src ? reg_sel_code : strap_q;
        cpu_run  = grp_en[0] & pd_n;
        pci_run  = grp_en[1] & pd_n;
        pcif_run = pd_n;
        out_oe   = ~reg_tristate;
        strap_oe = {SHARED_PINS{strap_done & ~reg_tristate}};
        vid_oe   = vid_en;
        vid_out  = vid_en ? reg_vid : '0;
    end

    // R9: power-down silences every group
    a_r9_pd_silences: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !pd_n |-> (!cpu_run && !pci_run && !pcif_run));

    // R2: shared pins never drive before capture completes
    a_r2_oe_after_capture: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (|strap_oe) |-> strap_done);

    // R6: the free-running PCI output runs whenever power is up
    a_r6_free_runs: assert property (@(posedge ref_clk) disable iff (!rst_n)
        pd_n |-> pcif_run);
endmodule

// File: tb/clk_gate_strap_ctrl_bench.sv
module clk_gate_strap_ctrl_bench;
    localparam int SD = 16;

    logic ref_clk = 0, cpu_clk = 0, pci_clk = 0;
    logic rst_n = 0, pd_n = 1;
    logic [4:0] strap_in = 5'h16;
    logic reg_sel_src = 0, reg_tristate = 0, wdog_en = 0;
    logic cpu_stop_n = 1, pci_stop_n = 1, vid_en = 0;
    logic [4:0] reg_sel_code = 0, reg_vid = 0;
    logic [4:0] sel_code, vid_out;
    logic strap_done, cpu_run, pci_run, pcif_run, out_oe, vid_oe;
    logic [2:0] strap_oe;

    int n_chk = 0, n_fail = 0, viol = 0;
    bit mon_on = 0;

    always #5 ref_clk = ~ref_clk;
    always #3 cpu_clk = ~cpu_clk;
    always #15 pci_clk = ~pci_clk;

    clk_gate_strap_ctrl #(.SAMPLE_DELAY(SD)) u_clk_gate_strap_ctrl (
        .ref_clk(ref_clk), .rst_n(rst_n), .pd_n(pd_n), .cpu_clk(cpu_clk),
        .pci_clk(pci_clk), .strap_in(strap_in), .reg_sel_src(reg_sel_src),
        .reg_sel_code(reg_sel_code), .reg_tristate(reg_tristate),
        .wdog_en(wdog_en), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
        .vid_en(vid_en), .reg_vid(reg_vid), .sel_code(sel_code),
        .strap_done(strap_done), .strap_oe(strap_oe), .cpu_run(cpu_run),
        .pci_run(pci_run), .pcif_run(pcif_run), .out_oe(out_oe),
        .vid_oe(vid_oe), .vid_out(vid_out)
    );

    // R8 monitor: run enables may only move while their group clock is low
    always @(cpu_run) if (mon_on && cpu_clk) viol++;
    always @(pci_run) if (mon_on && pci_clk) viol++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    // [27] src [26:22] code [21] tri [20] vid_en [19:15] vid |
    // [14:10] sel [9] oe [8:6] strap_oe [5] vid_oe [4:0] vid_out
    localparam logic [27:0] VEC [6] = '{
        {1'b0, 5'h03, 1'b0, 1'b1, 5'h15, 5'h16, 1'b1, 3'h7, 1'b1, 5'h15},
        {1'b1, 5'h03, 1'b0, 1'b0, 5'h15, 5'h03, 1'b1, 3'h7, 1'b0, 5'h00},
        {1'b1, 5'h1F, 1'b1, 1'b1, 5'h0A, 5'h1F, 1'b0, 3'h0, 1'b1, 5'h0A},
        {1'b0, 5'h1F, 1'b1, 1'b0, 5'h1F, 5'h16, 1'b0, 3'h0, 1'b0, 5'h00},
        {1'b1, 5'h00, 1'b0, 1'b1, 5'h1F, 5'h00, 1'b1, 3'h7, 1'b1, 5'h1F},
        {1'b0, 5'h0C, 1'b0, 1'b1, 5'h00, 5'h16, 1'b1, 3'h7, 1'b1, 5'h00}
    };

    initial begin
        fork
            begin
                cyc(3);
                chk("R1 done in reset", strap_done, 0);
                chk("R2 strap_oe in reset", strap_oe, 0);
                chk("R4 strap code before capture", sel_code, 0);
                chk("R5 cpu_run in reset", cpu_run, 1);
                rst_n = 1;
                cyc(SD - 2);
                chk("R1 not yet captured", strap_done, 0);
                chk("R2 strap_oe before capture", strap_oe, 0);
                cyc(5);
                chk("R1 captured", strap_done, 1);
                chk("R4 strap code", sel_code, 5'h16);
                chk("R2 strap_oe after capture", strap_oe, 3'h7);
                strap_in = 5'h09;
                cyc(3);
                chk("R3 code frozen", sel_code, 5'h16);
                chk("R1 done sticky", strap_done, 1);

                for (int i = 0; i < 6; i++) begin
                    reg_sel_src  = VEC[i][27];
                    reg_sel_code = VEC[i][26:22];
                    reg_tristate = VEC[i][21];
                    vid_en       = VEC[i][20];
                    reg_vid      = VEC[i][19:15];
                    cyc(1);
                    chk("R4 sel_code", sel_code, VEC[i][14:10]);
                    chk("R10 out_oe", out_oe, VEC[i][9]);
                    chk("R10 strap_oe", strap_oe, VEC[i][8:6]);
                    chk("R11 vid_oe", vid_oe, VEC[i][5]);
                    chk("R11 vid_out", vid_out, VEC[i][4:0]);
                end
                reg_tristate = 0;

                mon_on = 1;
                cpu_stop_n = 0;
                cyc(20);
                chk("R5 cpu stopped", cpu_run, 0);
                chk("R5 pci unaffected", pci_run, 1);
                chk("R5 pcif unaffected", pcif_run, 1);
                cpu_stop_n = 1;
                cyc(20);
                chk("R5 cpu restarted", cpu_run, 1);
                pci_stop_n = 0;
                cyc(30);
                chk("R6 pci stopped", pci_run, 0);
                chk("R6 pcif runs", pcif_run, 1);
                chk("R6 cpu unaffected", cpu_run, 1);
                wdog_en = 1;
                cyc(30);
                chk("R7 watchdog masks stop", pci_run, 1);
                wdog_en = 0;
                cyc(30);
                chk("R7 stop returns without mask", pci_run, 0);
                pci_stop_n = 1;
                cyc(30);
                chk("R6 pci restarted", pci_run, 1);
                mon_on = 0;
                chk("R8 edges only while clock low", viol, 0);

                // power-down together with a masked PCI stop
                pci_stop_n = 0;
                wdog_en = 1;
                cyc(30);
                #1 pd_n = 0;
                #1;
                chk("R9 cpu off at once", cpu_run, 0);
                chk("R9 pci off despite mask", pci_run, 0);
                chk("R9 pcif off", pcif_run, 0);
                cyc(2);
                pd_n = 1;
                cyc(30);
                chk("R9 pci back, mask still on", pci_run, 1);
                chk("R9 cpu back", cpu_run, 1);
                chk("R9 pcif back", pcif_run, 1);
            end
            begin
                repeat (100000) @(posedge ref_clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule